// File: doc/BRIEF.md
# Routed Interrupt Aggregation Controller

The controller gathers up to 32 peripheral interrupt lines and steers each one onto one or more of four parent interrupt lines that go to a single CPU core. Every input is first brought to a common active-high sense by a per-input polarity bit. A per-input mode bit then selects how it is seen. A level input reports its current state. An edge input latches a pending bit on each rising transition and holds it until software clears it.

Software sees a 32-bit register bus. The route table holds one byte per input at the byte offset equal to the input number, and byte-lane enables let software write a single route byte. The enable mask can only be changed through a write-one-to-set word and a write-one-to-clear word. The set word also reads back the current mask. A status word in a second region reports every active input, whether it is enabled or not. A handler reads the status word, ANDs it with the enables and services the lowest set bit.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every input is disabled, the polarity, mode and route registers hold 0, `irq_o` is 0, and reads of the route words, 0x28, 0x30 and 0x34 return 0.
- R2: The route byte of input n sits at byte offset n, inside word `n/4` at lane `n%4`. A write changes only the lanes whose `be_i` bit is 1, and the word reads back as written.
- R3: A write to 0x28 sets the enable of every input whose data bit is 1 and leaves the other enables unchanged. A read of 0x28 returns the enable mask.
- R4: A write to 0x2C clears the enable of every input whose data bit is 1, so writing all ones disables everything. A read of 0x2C returns 0.
- R5: Polarity register 0x30: a 1 bit makes that input active-low, and a 0 bit keeps it active-high.
- R6: Mode register 0x34: a 0 bit makes the input level-sensitive. Its status bit and its effect on `irq_o` follow the input and drop when the input deasserts. No end-of-interrupt write is needed.
- R7: A 1 bit in 0x34 makes the input edge-sensitive. A rising transition of the active-high input sets a pending bit that holds after the input falls. Writing 1 to that bit of the status word at 0x40 clears it. Writing 0 leaves it set.
- R8: Parent output k is 1 when some input is enabled, active, has route bit 0 (CPU core 0) set and has route bit 4+k set. An input with several of bits 4..7 set drives all of the selected outputs. An input with bit 0 clear drives none.
- R9: A read of 0x40 returns the status of every input, enabled or not.
- R10: Reads of offsets with no register (0x20..0x27, 0x38, 0x3C, 0x44 and above) return 0. Writes to them change no state.
- R11: Read data appears on `rdata_o` one cycle after the read request. `irq_o` is registered, so it follows a change of a level input's status one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 7 | Byte address; bits 1:0 are ignored; 0x40 is the status region |
| be_i | input | 4 | Byte-lane enables, applied to route-table writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| src_i | input | NUM_IN | Peripheral interrupt inputs, synchronous to clk_i |
| irq_o | output | NUM_PARENT | Parent interrupt outputs to the CPU core |

## Verification
The hardest state to reach is an edge input that still holds its pending bit after its source has dropped. The bench reaches it by enabling edge mode, pulsing the input high for a few cycles and then releasing it. It then checks that the parent output and the status bit stay set. They must survive a status write with a 0 in that bit and fall only on a write of 1. A second hard case is an input that is active but masked off, so that status and output disagree. The bench reaches it by clearing one enable bit while holding that input high, then reading the status word to confirm the bit is still reported.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned REG_AW     = 7;
  localparam int unsigned DATA_W     = 32;
  localparam logic [REG_AW-1:0] OFS_EN_SET = 7'h28;
  localparam logic [REG_AW-1:0] OFS_EN_CLR = 7'h2C;
  localparam logic [REG_AW-1:0] OFS_POL    = 7'h30;
  localparam logic [REG_AW-1:0] OFS_MODE   = 7'h34;
  localparam logic [REG_AW-1:0] OFS_STAT   = 7'h40;
  localparam int unsigned RT_CPU_BIT = 0;
  localparam int unsigned RT_INT_LSB = 4;
  typedef logic [7:0] route_byte_t;
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file import irq_route_pkg::*; #(
  parameter int unsigned NUM_IN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [3:0]          be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_IN-1:0]   status_i,
  output logic [NUM_IN*8-1:0] route_o,
  output logic [NUM_IN-1:0]   en_o,
  output logic [NUM_IN-1:0]   pol_o,
  output logic [NUM_IN-1:0]   mode_o,
  output logic [NUM_IN-1:0]   clr_pend_o
);
  localparam int unsigned RT_WORDS = (NUM_IN + 3) / 4;

  logic [NUM_IN*8-1:0] route_q;
  logic [NUM_IN-1:0]   en_q, pol_q, mode_q;
  logic [REG_AW-1:0]   wa;
  logic [REG_AW-3:0]   widx;
  logic                wr, rd;
  logic [DATA_W-1:0]   rd_d;

  assign widx = addr_i[REG_AW-1:2];
  assign wa   = {widx, 2'b00};
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (widx == (REG_AW-2)'(i / 4) && be_i[i % 4])
          route_q[8*i +: 8] <= wdata_i[8*(i % 4) +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (wr) begin
      case (wa)
        OFS_EN_SET: en_q   <= en_q | wdata_i[NUM_IN-1:0];
        OFS_EN_CLR: en_q   <= en_q & ~wdata_i[NUM_IN-1:0];
        OFS_POL:    pol_q  <= wdata_i[NUM_IN-1:0];
        OFS_MODE:   mode_q <= wdata_i[NUM_IN-1:0];
        default: ;
      endcase
    end
  end

  // W1C of edge pending bits through the status word
  assign clr_pend_o = (wr && wa == OFS_STAT) ? wdata_i[NUM_IN-1:0] : '0;

  always_comb begin
    rd_d = '0;
    if (widx < (REG_AW-2)'(RT_WORDS)) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (widx == (REG_AW-2)'(i / 4))
          rd_d[8*(i % 4) +: 8] = route_q[8*i +: 8];
      end
    end else begin
      case (wa)
        OFS_EN_SET: rd_d[NUM_IN-1:0] = en_q;
        OFS_POL:    rd_d[NUM_IN-1:0] = pol_q;
        OFS_MODE:   rd_d[NUM_IN-1:0] = mode_q;
        OFS_STAT:   rd_d[NUM_IN-1:0] = status_i;
        default:    rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned NUM_IN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] src_i,
  input  logic [NUM_IN-1:0] pol_i,
  input  logic [NUM_IN-1:0] mode_i,
  input  logic [NUM_IN-1:0] clr_i,
  output logic [NUM_IN-1:0] status_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_src
    logic act, prev_q, pend_q;
    assign act = src_i[i] ^ pol_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= act;
        if (!mode_i[i])           pend_q <= 1'b0;
        else if (act && !prev_q)  pend_q <= 1'b1;  // new edge beats clear
        else if (clr_i[i])        pend_q <= 1'b0;
      end
    end

    assign status_o[i] = mode_i[i] ? pend_q : act;
  end
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge import irq_route_pkg::*; #(
  parameter int unsigned NUM_IN     = 32,
  parameter int unsigned NUM_PARENT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_IN-1:0]     en_i,
  input  logic [NUM_IN-1:0]     status_i,
  input  logic [NUM_IN*8-1:0]   route_i,
  output logic [NUM_PARENT-1:0] irq_o
);
  logic [NUM_IN-1:0]     live;
  logic [NUM_PARENT-1:0] irq_d;

  assign live = en_i & status_i;

  for (genvar k = 0; k < NUM_PARENT; k++) begin : g_par
    logic [NUM_IN-1:0] hit;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign hit[i] = live[i] & route_i[8*i + RT_CPU_BIT] & route_i[8*i + RT_INT_LSB + k];
    end
    assign irq_d[k] = |hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl import irq_route_pkg::*; #(
  parameter int unsigned NUM_IN     = 32,
  parameter int unsigned NUM_PARENT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [3:0]            be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_IN-1:0]     src_i,
  output logic [NUM_PARENT-1:0] irq_o
);
  logic [NUM_IN*8-1:0] route_w;
  logic [NUM_IN-1:0]   en_w, pol_w, mode_w, clr_pend_w, status_w;

  irq_reg_file #(.NUM_IN(NUM_IN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .be_i       (be_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .status_i   (status_w),
    .route_o    (route_w),
    .en_o       (en_w),
    .pol_o      (pol_w),
    .mode_o     (mode_w),
    .clr_pend_o (clr_pend_w)
  );

  irq_src_cond #(.NUM_IN(NUM_IN)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .pol_i    (pol_w),
    .mode_i   (mode_w),
    .clr_i    (clr_pend_w),
    .status_o (status_w)
  );

  irq_route_merge #(.NUM_IN(NUM_IN), .NUM_PARENT(NUM_PARENT)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .status_i (status_w),
    .route_i  (route_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk import irq_route_pkg::*; #(
  parameter int unsigned NUM_IN     = 32,
  parameter int unsigned NUM_PARENT = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [REG_AW-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [NUM_IN-1:0]     en_i,
  input logic [NUM_IN-1:0]     mode_i,
  input logic [NUM_IN-1:0]     status_i,
  input logic [NUM_IN-1:0]     clr_i,
  input logic [NUM_IN*8-1:0]   route_i,
  input logic [NUM_PARENT-1:0] irq_o
);
  logic [NUM_IN-1:0] cpu_sel;
  logic              set_wr, clr_wr;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) cpu_sel[i] = route_i[8*i + RT_CPU_BIT];
  end

  assign set_wr = req_i && we_i && {addr_i[REG_AW-1:2], 2'b00} == OFS_EN_SET;
  assign clr_wr = req_i && we_i && {addr_i[REG_AW-1:2], 2'b00} == OFS_EN_CLR;

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((en_i & $past(wdata_i[NUM_IN-1:0])) == $past(wdata_i[NUM_IN-1:0])));

  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((en_i & $past(wdata_i[NUM_IN-1:0])) == '0));

  // R7
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_i & mode_i) & mode_i & ~$past(clr_i) & ~status_i) == '0));

  // R8
  no_cpu_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_sel == '0) |=> (irq_o == '0));

  // R8
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(en_i & status_i) != '0));
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_IN(NUM_IN), .NUM_PARENT(NUM_PARENT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .en_i     (en_w),
  .mode_i   (mode_w),
  .status_i (status_w),
  .clr_i    (clr_pend_w),
  .route_i  (route_w),
  .irq_o    (irq_o)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_route_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); d = rdata; req = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {28'd0, irq}, 32'd0);
    rd(7'h28, d); chk("R1 enable", d, 32'd0);
    rd(7'h30, d); chk("R1 polarity", d, 32'd0);
    rd(7'h34, d); chk("R1 mode", d, 32'd0);
    for (int w = 0; w < 8; w++) begin
      rd(7'(w * 4), d); chk("R1 route", d, 32'd0);
    end

    // R2 byte lanes and readback
    wr(7'h04, 32'hAABBCCDD, 4'b0101);
    rd(7'h04, d); chk("R2 lanes", d, 32'h00BB00DD);
    for (int w = 0; w < 8; w++) wr(7'(w * 4), 32'h01010101 * (w + 3), 4'hF);
    for (int w = 0; w < 8; w++) begin
      rd(7'(w * 4), d); chk("R2 word", d, 32'h01010101 * (w + 3));
    end

    // R3 / R4 enable set and clear
    wr(7'h28, 32'hF0F00001, 4'hF);
    rd(7'h28, d); chk("R3 set", d, 32'hF0F00001);
    wr(7'h28, 32'h00000010, 4'hF);
    rd(7'h28, d); chk("R3 set keeps", d, 32'hF0F00011);
    wr(7'h2C, 32'h00000011, 4'hF);
    rd(7'h28, d); chk("R4 clear", d, 32'hF0F00000);
    rd(7'h2C, d); chk("R4 read zero", d, 32'd0);
    wr(7'h2C, 32'hFFFFFFFF, 4'hF);
    rd(7'h28, d); chk("R4 clear all", d, 32'd0);
    wr(7'h28, 32'hFFFFFFFF, 4'hF);

    // R8 sweep: input i routed to parent i%4, one byte-lane write each
    for (int i = 0; i < 32; i++) begin
      logic [7:0] rb;
      rb = 8'h01 | (8'h10 << (i % 4));
      wr(7'((i / 4) * 4), 32'(rb) << (8 * (i % 4)), 4'b0001 << (i % 4));
    end
    for (int i = 0; i < 32; i++) begin
      src = 32'd1 << i;
      settle();
      chk("R8 route sweep", {28'd0, irq}, 32'd1 << (i % 4));
      rd(7'h40, d); chk("R9 status sweep", d, 32'd1 << i);
      src = '0;
    end
    settle();

    // R8 multiple parents, and CPU bit clear
    wr(7'h04, 32'h0000F100, 4'b0010);
    src = 32'd1 << 5; settle();
    chk("R8 multi", {28'd0, irq}, 32'hF);
    wr(7'h04, 32'h0000F000, 4'b0010); settle();
    chk("R8 no cpu", {28'd0, irq}, 32'h0);
    wr(7'h04, 32'h00002100, 4'b0010); settle();
    chk("R8 restored", {28'd0, irq}, 32'h2);

    // R9 masked input still reported
    wr(7'h2C, 32'd1 << 5, 4'hF); settle();
    chk("R9 masked irq", {28'd0, irq}, 32'h0);
    rd(7'h40, d); chk("R9 masked status", d, 32'd1 << 5);
    wr(7'h28, 32'd1 << 5, 4'hF);
    src = '0; settle();

    // R5 polarity
    wr(7'h30, 32'd1 << 3, 4'hF); settle();
    chk("R5 active low idle", {28'd0, irq}, 32'h8);
    src = 32'd1 << 3; settle();
    chk("R5 active low driven", {28'd0, irq}, 32'h0);
    wr(7'h30, 32'd0, 4'hF); src = '0; settle();

    // R6 level mode
    src = 32'd1 << 2; settle();
    chk("R6 level high", {28'd0, irq}, 32'h4);
    src = '0; settle();
    chk("R6 level drop", {28'd0, irq}, 32'h0);
    rd(7'h40, d); chk("R6 status drop", d, 32'd0);

    // R7 edge mode
    wr(7'h34, 32'd1 << 7, 4'hF); settle();
    chk("R7 no spurious", {28'd0, irq}, 32'h0);
    src = 32'd1 << 7; settle();
    src = '0; settle();
    chk("R7 held", {28'd0, irq}, 32'h8);
    rd(7'h40, d); chk("R7 status held", d, 32'd1 << 7);
    wr(7'h40, 32'd0, 4'hF); settle();
    chk("R7 zero write", {28'd0, irq}, 32'h8);
    wr(7'h40, 32'd1 << 7, 4'hF); settle();
    chk("R7 cleared", {28'd0, irq}, 32'h0);
    rd(7'h40, d); chk("R7 status cleared", d, 32'd0);
    wr(7'h34, 32'd0, 4'hF);

    // R10 unmapped offsets
    wr(7'h20, 32'hFFFFFFFF, 4'hF);
    wr(7'h38, 32'hFFFFFFFF, 4'hF);
    rd(7'h20, d); chk("R10 0x20", d, 32'd0);
    rd(7'h24, d); chk("R10 0x24", d, 32'd0);
    rd(7'h38, d); chk("R10 0x38", d, 32'd0);
    rd(7'h3C, d); chk("R10 0x3C", d, 32'd0);
    rd(7'h44, d); chk("R10 0x44", d, 32'd0);
    rd(7'h28, d); chk("R10 enable kept", d, 32'hFFFFFFFF);
    rd(7'h30, d); chk("R10 polarity kept", d, 32'd0);
    rd(7'h00, d); chk("R10 route kept", d, 32'h81412111);

    // R11 output latency
    @(negedge clk); src = 32'd1;
    #1 chk("R11 before edge", {28'd0, irq}, 32'h0);
    @(negedge clk); chk("R11 one cycle", {28'd0, irq}, 32'h1);
    src = '0; settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule